// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial byte memory. It oversamples the clock and data lines with the system clock and recognises start and stop conditions. It checks the device address against a fixed code and three strap pins, takes a two-byte word address and acknowledges every byte it accepts. Read data goes out through an open-drain pull-down enable. A synchronous register array stands in for the storage cells.

Written bytes go into the current page. Only the low page bits of the word address step, so a long burst wraps within the page. A stop that ends a write with at least one data byte starts a timed internal write cycle. During that cycle the slave ignores its own address. Reads come in three forms: a current-address read, a random read built from a dummy write and a repeated start, and a sequential read driven by master acknowledges. In a read, the word counter steps on the falling clock edge of the eighth data bit. The array depth is set by `ADDR_W` (8192 words at `ADDR_W = 13`, 2048 words by default).

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the slave releases SDA (`sda_pull_o` = 0) and stays idle until a start condition.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop during a read ends the read, and the slave then leaves SDA released under further SCL pulses until the next start.
- R3: The first byte after a start is sent MSB first: bits 7..4 must be 1010, bits 3..1 must equal `strap_i[2:0]`, and bit 0 selects read (1) or write (0). On a match the slave pulls SDA low during the 9th SCL clock. On a mismatch it leaves SDA released for that clock and for every later byte until the next start.
- R4: In a write, the slave acknowledges the word-address high byte, then the low byte, then each data byte. The word address is high byte bits [ADDR_W-9:0] joined to the low byte, and the other high-byte bits are ignored. Each data byte is stored at the current word address.
- R5: After each stored byte, only the low 5 address bits (the page offset) step, modulo 32. The bits above them are kept, so byte 33 of a burst overwrites byte 1.
- R6: A stop after one or more stored data bytes starts an internal write cycle of `WR_CYCLES` clocks. During this cycle a matching device address gets no acknowledge. A dummy write (address bytes only, then a stop) starts no write cycle.
- R7: A read sends the word at the current address MSB first, with each bit changing while SCL is low. The address counter steps by one on the SCL falling edge of the 8th data bit, so a current-address read continues after the last word touched.
- R8: A random read is a dummy write that loads the word address, then a repeated start and a read device address. The first byte returned is the word at the loaded address.
- R9: While the master acknowledges each read byte, the slave keeps sending consecutive words. After the highest address it wraps to address 0.
- R10: A master not-acknowledge after a read byte ends the read. The slave then keeps SDA released until a start.
- R11: SDA is only pulled low or released. The pull-down enable never changes while SCL stays high, except at a start or a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the wire |
| strap_i | input | 3 | Strap levels compared with device-address bits 3..1 |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume that SCL and SDA are slow next to `clk`. Every SCL level must last several system clocks, and SDA must change at least one clock after an SCL edge. Under these conditions the three-stage samplers keep the order of the two lines, and a start or stop never coincides with a sampled clock edge. The bench master holds each SCL phase for eight clocks and moves SDA two clocks into the low phase. It issues stops only when the slave has released the line. It waits longer than the write cycle before any access that must be acknowledged.

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 1000000,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_pull_o
);
  localparam int WORDS  = 1 << ADDR_W;
  localparam int BUSY_W = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WR, S_RD, S_SKIP} st_t;

  logic [2:0] scl_q, sda_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  wire scl_h   = scl_q[1];
  wire scl_p   = scl_q[2];
  wire sda_h   = sda_q[1];
  wire sda_p   = sda_q[2];
  wire scl_rise = scl_h & ~scl_p;
  wire scl_fall = ~scl_h & scl_p;
  wire start_c  = scl_h & scl_p & sda_p & ~sda_h;
  wire stop_c   = scl_h & scl_p & ~sda_p & sda_h;

  st_t                st;
  logic [3:0]         cnt;
  logic [7:0]         sr;
  logic [6:0]         tx;
  logic [ADDR_W-1:0]  addr;
  logic               oe, mack, wrote;
  logic [BUSY_W-1:0]  busy_cnt;
  logic [7:0]         rdq;
  logic [7:0]         mem [WORDS];

  wire dev_hit = (sr[7:4] == DEV_CODE) && (sr[3:1] == strap_i) && (busy_cnt == '0);
  wire wr_en   = (st == S_WR) && scl_fall && (cnt == 4'd8);
  wire rx_st   = (st == S_DEV) || (st == S_AHI) || (st == S_ALO) || (st == S_WR);

  assign sda_pull_o = oe;

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= sr;
    rdq <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sr       <= '0;
      tx       <= '0;
      addr     <= '0;
      oe       <= 1'b0;
      mack     <= 1'b0;
      wrote    <= 1'b0;
      busy_cnt <= '0;
    end else begin
      if (busy_cnt != '0) busy_cnt <= busy_cnt - BUSY_W'(1);
      if (start_c) begin
        st    <= S_DEV;
        cnt   <= '0;
        oe    <= 1'b0;
        wrote <= 1'b0;
      end else if (stop_c) begin
        st  <= S_IDLE;
        cnt <= '0;
        oe  <= 1'b0;
        if (wrote) busy_cnt <= BUSY_W'(WR_CYCLES);
        wrote <= 1'b0;
      end else if (scl_rise) begin
        if (rx_st) begin
          if (cnt < 4'd8) sr <= {sr[6:0], sda_h};
          cnt <= cnt + 4'd1;
        end else if (st == S_RD) begin
          if (cnt == 4'd8) mack <= ~sda_h;
          cnt <= cnt + 4'd1;
        end
      end else if (scl_fall) begin
        if (rx_st) begin
          if (cnt == 4'd8) begin
            case (st)
              S_DEV: if (dev_hit) oe <= 1'b1; else st <= S_SKIP;
              S_AHI: begin
                addr <= {sr[ADDR_W-9:0], addr[7:0]};
                oe   <= 1'b1;
              end
              S_ALO: begin
                addr[7:0] <= sr;
                oe        <= 1'b1;
              end
              default: begin
                addr  <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};
                wrote <= 1'b1;
                oe    <= 1'b1;
              end
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            oe  <= 1'b0;
            case (st)
              S_DEV: if (sr[0]) begin
                st <= S_RD;
                tx <= rdq[6:0];
                oe <= ~rdq[7];
              end else st <= S_AHI;
              S_AHI: st <= S_ALO;
              S_ALO: st <= S_WR;
              default: ;
            endcase
          end
        end else if (st == S_RD) begin
          if (cnt == 4'd8) begin
            oe   <= 1'b0;
            addr <= addr + ADDR_W'(1);
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            if (mack) begin
              tx <= rdq[6:0];
              oe <= ~rdq[7];
            end else st <= S_SKIP;
          end else if (cnt != 4'd0) begin
            tx <= {tx[5:0], 1'b0};
            oe <= ~tx[6];
          end
        end
      end
    end
  end

  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !oe);

  a_r5_page_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));

  a_r6_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEV && scl_fall && cnt == 4'd8 && busy_cnt != '0) |=> (!oe && st == S_SKIP));

  a_r7_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && scl_fall && cnt == 4'd8) |=> addr == $past(addr) + ADDR_W'(1));

  a_r10_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> !oe);

  a_r11_oe_moves_on_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (oe != $past(oe)) |-> $past(scl_fall || start_c || stop_c));
endmodule

// File: tb/sim_serial_eeprom_slave.sv
`timescale 1ns/100ps
module sim_serial_eeprom_slave;
  localparam int H   = 8;
  localparam int WRC = 300;
  localparam int AW  = 11;
  localparam int NW  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic [2:0] strap = 3'b101;
  wire  s_low;
  wire  sda_bus = ~(m_low | s_low);

  int vectors = 0, errors = 0, viol = 0, hi_cnt = 0, cur = 0;
  logic prev_s = 1'b0;
  logic [7:0] mem_m [NW];
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_eeprom_slave #(.ADDR_W(AW), .PAGE_W(5), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(strap), .sda_pull_o(s_low));

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // R11 monitor: no change of the pull-down while SCL has been high a while
  always @(negedge clk) begin
    hi_cnt = scl ? hi_cnt + 1 : 0;
    if (rst_n && hi_cnt >= 5 && s_low != prev_s) viol++;
    prev_s = s_low;
  end

  task automatic bus_start;
    m_low = 1'b0; tick(H); scl = 1'b1; tick(H); m_low = 1'b1; tick(H); scl = 1'b0; tick(H);
  endtask

  task automatic bus_stop;
    m_low = 1'b1; tick(H); scl = 1'b1; tick(H); m_low = 1'b0; tick(H);
  endtask

  task automatic put_byte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tick(2); m_low = ~b[i]; tick(H-2); scl = 1'b1; tick(H); scl = 1'b0;
    end
    tick(2); m_low = 1'b0; tick(H-2); scl = 1'b1; tick(H/2);
    ack = ~sda_bus; tick(H/2); scl = 1'b0;
  endtask

  task automatic get_byte(bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl = 1'b1; tick(H/2); b[i] = sda_bus; tick(H/2); scl = 1'b0;
    end
    tick(2); m_low = give_ack; tick(H-2); scl = 1'b1; tick(H); scl = 1'b0;
    tick(2); m_low = 1'b0;
  endtask

  task automatic idle_pulses(string req);
    for (int i = 0; i < 9; i++) begin
      tick(H); scl = 1'b1; tick(H/2); chk(sda_bus == 1'b1, req, sda_bus, 1); tick(H/2); scl = 1'b0;
    end
  endtask

  function automatic logic [7:0] dev(bit rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic send_addr(int a, string req);
    bit ack;
    put_byte({5'b10101, 3'(a >> 8)}, ack); chk(ack, req, ack, 1);
    put_byte(8'(a), ack); chk(ack, req, ack, 1);
  endtask

  task automatic write_burst(int a, int n, int salt);
    bit ack;
    logic [7:0] d;
    int wa;
    bus_start;
    put_byte(dev(0), ack); chk(ack, "R4 device ack", ack, 1);
    send_addr(a, "R4 address ack");
    for (int i = 0; i < n; i++) begin
      d = 8'((i * 37 + salt) & 255);
      put_byte(d, ack); chk(ack, "R4 data ack", ack, 1);
      wa = (a & ~31) | ((a + i) & 31);
      mem_m[wa] = d;
    end
    bus_stop;
    cur = (a & ~31) | ((a + n) & 31);
  endtask

  task automatic read_run(int n, string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, b);
      chk(b == mem_m[cur], req, b, mem_m[cur]);
      cur = (cur + 1) % NW;
    end
  endtask

  task automatic random_read(int a, int n, string req);
    bit ack;
    bus_start;
    put_byte(dev(0), ack); chk(ack, "R8 dummy write ack", ack, 1);
    send_addr(a, "R8 address ack");
    bus_start;
    put_byte(dev(1), ack); chk(ack, "R8 read ack", ack, 1);
    cur = a;
    read_run(n, req);
    bus_stop;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    tick(190000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    int a;
    tick(4);
    chk(s_low == 1'b0, "R1 released in reset", s_low, 0);
    rst_n = 1'b1;
    tick(20);
    chk(s_low == 1'b0, "R1 released after reset", s_low, 0);

    // R3 wrong code, then later bytes ignored
    bus_start;
    put_byte({4'b1011, strap, 1'b0}, ack); chk(!ack, "R3 wrong code nack", ack, 0);
    put_byte(8'h00, ack); chk(!ack, "R3 later byte ignored", ack, 0);
    bus_stop;
    // R3 wrong strap
    bus_start;
    put_byte({4'b1010, ~strap, 1'b1}, ack); chk(!ack, "R3 wrong strap nack", ack, 0);
    bus_stop;

    // R4 write six bytes, R6 busy
    write_burst(12'h123, 6, 5);
    bus_start;
    put_byte(dev(0), ack); chk(!ack, "R6 busy nack", ack, 0);
    bus_stop;
    tick(WRC + 100);

    // R8 random read, R9 sequential, then R7 current-address read with R10 nack
    random_read(12'h123, 4, "R8 R9 random sequential read");
    bus_start;
    put_byte(dev(1), ack); chk(ack, "R7 current read ack", ack, 1);
    read_run(1, "R7 current address data");
    idle_pulses("R10 released after nack");
    bus_stop;

    // R6 dummy write starts no write cycle
    bus_start;
    put_byte(dev(0), ack); chk(ack, "R6 dummy ack", ack, 1);
    send_addr(12'h124, "R6 dummy address");
    bus_stop;
    bus_start;
    put_byte(dev(1), ack); chk(ack, "R6 no busy after dummy", ack, 1);
    cur = 12'h124;
    read_run(1, "R6 dummy then read");
    bus_stop;

    // R5 page rollover
    write_burst(30, 34, 11);
    tick(WRC + 100);
    random_read(0, 32, "R5 page rollover contents");

    // R9 wrap to zero
    write_burst(NW - 2, 2, 99);
    tick(WRC + 100);
    random_read(NW - 2, 3, "R9 wrap past top");

    // R2 stop during read
    a = 0;
    for (int i = 0; i < 31; i++) if (mem_m[i+1][7] && a == 0) a = i + 1;
    a = a - 1;
    bus_start;
    put_byte(dev(0), ack);
    send_addr(a, "R2 address ack");
    bus_start;
    put_byte(dev(1), ack); chk(ack, "R2 read ack", ack, 1);
    get_byte(1'b1, b); chk(b == mem_m[a], "R2 first byte", b, mem_m[a]);
    bus_stop;
    idle_pulses("R2 released after stop");
    bus_start;
    put_byte(dev(1), ack); chk(ack, "R7 ack after stop", ack, 1);
    cur = a + 1;
    read_run(1, "R7 R2 counter after stop");
    bus_stop;

    chk(viol == 0, "R11 no pull change in SCL high", viol, 0);
    done = 1;
    finish_run;
  end
endmodule